// File: doc/BRIEF.md
# Interrupt Aggregation Controller

This block collects up to 32 interrupt sources and merges them into a single request line for a processor. Software reaches it through a small 32-bit register bus. The bus has a byte address, a write strobe, write data and read data that is registered one cycle after the address. Each source is fixed at build time as either edge sensitive or level sensitive. For every source the block keeps a latched status bit and an enable bit. It exposes the pending set, which is status AND enable, and a vector register that names the lowest-numbered pending source.

Software enables and masks sources either by writing the whole enable word or by writing a mask to a set-enable or clear-enable register. It acknowledges sources by writing a mask to a write-one-to-clear register. The request line is gated by a two-bit master control. The hardware-enable bit in that control can only be set and stays set until reset. The register offsets are fixed because software depends on them: status 0x00, pending 0x04, enable 0x08, acknowledge 0x0C, set-enable 0x10, clear-enable 0x14, vector 0x18, master 0x1C.

Top module: `irq_hub`

## Requirements
- R1: After reset, the status, enable and master registers are zero, `irq_out` is low and `bus_rdata` is zero.
- R2: A source whose bit in `EDGE_MASK` is 1 sets its status bit on a 0-to-1 transition. The bit stays set after the source falls, and a source that is held high does not set it again once it has been acknowledged.
- R3: A source whose bit in `EDGE_MASK` is 0 sets its status bit in every cycle it is high. An acknowledge while the source is still high has no lasting effect. An acknowledge after the source has gone low clears the bit.
- R4: A write to enable (0x08) replaces every enable bit. Writing zero masks all sources.
- R5: A write to set-enable (0x10) sets the enable bits where the data has ones, and a write to clear-enable (0x14) clears them. In both cases all other enable bits keep their value.
- R6: A write to acknowledge (0x0C) clears only the status bits where the data has ones. Writing 0xFFFFFFFF clears every status bit.
- R7: Pending (0x04) reads status AND enable. Status bits latch even for disabled sources.
- R8: Vector (0x18) reads the index of the lowest-numbered pending source, or 0xFFFFFFFF when nothing is pending.
- R9: Master (0x1C) holds the master enable in bit 0 and the hardware enable in bit 1. Writing 0x3 reads back 0x3. Bit 1 cannot be cleared except by reset. `irq_out` is high one cycle after bit 0, bit 1 and at least one pending bit are all set.
- R10: `bus_rdata` presents the register addressed in the previous cycle. The write-only registers (0x0C, 0x10, 0x14) and addresses from 0x20 upward read zero. Writes to status, pending and vector are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the previous cycle's address |
| src_in | input | NUM_IN | Interrupt sources |
| irq_out | output | 1 | Registered interrupt request to the processor |

## Verification
The hardest case to reach is a level source that is acknowledged while it is still asserted. Reaching it needs the source held high across a register write, and the surviving status bit must then be read back before the source is released. The bench holds a level input high, enables it, acknowledges it, and reads status twice: once while the input is high and once after it drops and is acknowledged again. A similar sequence holds an edge source high across an acknowledge to show that it does not re-latch. The vector priority is checked with an edge source and a level source pending at the same time.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;
  // Word index of each register (byte address bits [4:2]); software relies on this map.
  typedef enum logic [2:0] {
    SEL_STAT   = 3'd0,
    SEL_PEND   = 3'd1,
    SEL_EN     = 3'd2,
    SEL_ACK    = 3'd3,
    SEL_SETEN  = 3'd4,
    SEL_CLREN  = 3'd5,
    SEL_VEC    = 3'd6,
    SEL_MASTER = 3'd7
  } reg_sel_e;

  localparam int unsigned DATA_W    = 32;
  localparam int unsigned MAP_BITS  = 5;   // byte address bits covered by the map
  localparam logic [DATA_W-1:0] VEC_NONE = '1;
endpackage

// File: rtl/irq_hub_detect.sv
module irq_hub_detect #(
  parameter int unsigned      NUM_IN    = 32,
  parameter logic [31:0]      EDGE_MASK = 32'h0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_IN-1:0] src_in,
  output logic [NUM_IN-1:0] set_evt
);
  logic [NUM_IN-1:0] smp_q;
  logic [NUM_IN-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      smp_q  <= '0;
      prev_q <= '0;
    end else begin
      smp_q  <= src_in;
      prev_q <= smp_q;
    end
  end

  for (genvar i = 0; i < NUM_IN; i++) begin : g_src
    if (EDGE_MASK[i]) begin : g_edge
      assign set_evt[i] = smp_q[i] & ~prev_q[i];
    end else begin : g_level
      assign set_evt[i] = smp_q[i];
    end
  end
endmodule

// File: rtl/irq_hub_state.sv
module irq_hub_state #(
  parameter int unsigned NUM_IN = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_IN-1:0] set_evt,
  input  logic [NUM_IN-1:0] wr_data,
  input  logic              ack_wr,
  input  logic              en_wr,
  input  logic              en_set,
  input  logic              en_clr,
  output logic [NUM_IN-1:0] status,
  output logic [NUM_IN-1:0] enable
);
  logic [NUM_IN-1:0] ack_mask;
  logic [NUM_IN-1:0] en_next;

  assign ack_mask = ack_wr ? wr_data : '0;

  always_comb begin
    en_next = enable;
    if (en_wr)       en_next = wr_data;
    else if (en_set) en_next = enable | wr_data;
    else if (en_clr) en_next = enable & ~wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status <= '0;
      enable <= '0;
    end else begin
      // A new event in the same cycle wins over the acknowledge.
      status <= (status & ~ack_mask) | set_evt;
      enable <= en_next;
    end
  end
endmodule

// File: rtl/irq_hub_prio.sv
module irq_hub_prio #(
  parameter int unsigned NUM_IN = 32,
  localparam int unsigned IDX_W = (NUM_IN > 1) ? $clog2(NUM_IN) : 1
) (
  input  logic [NUM_IN-1:0] req,
  output logic              found,
  output logic [IDX_W-1:0]  idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = NUM_IN - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_hub.sv
module irq_hub
  import irq_hub_pkg::*;
#(
  parameter int unsigned NUM_IN    = 32,
  parameter int unsigned ADDR_W    = 8,
  parameter logic [31:0] EDGE_MASK = 32'h0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NUM_IN-1:0] src_in,
  output logic              irq_out
);
  localparam int unsigned IDX_W = (NUM_IN > 1) ? $clog2(NUM_IN) : 1;

  reg_sel_e          sel;
  logic              in_map;
  logic              wr_hit;
  logic [NUM_IN-1:0] set_w;
  logic [NUM_IN-1:0] stat_w;
  logic [NUM_IN-1:0] en_w;
  logic [NUM_IN-1:0] pend_w;
  logic              found_w;
  logic [IDX_W-1:0]  idx_w;
  logic              me_q;
  logic              hie_q;
  logic [31:0]       rd_next;

  assign sel    = reg_sel_e'(bus_addr[MAP_BITS-1:2]);
  assign in_map = (bus_addr >> MAP_BITS) == '0;
  assign wr_hit = bus_we & in_map;

  irq_hub_detect #(.NUM_IN(NUM_IN), .EDGE_MASK(EDGE_MASK)) detect_i (
    .clk(clk), .rst(rst), .src_in(src_in), .set_evt(set_w)
  );

  irq_hub_state #(.NUM_IN(NUM_IN)) state_i (
    .clk(clk), .rst(rst), .set_evt(set_w),
    .wr_data(bus_wdata[NUM_IN-1:0]),
    .ack_wr(wr_hit && sel == SEL_ACK),
    .en_wr (wr_hit && sel == SEL_EN),
    .en_set(wr_hit && sel == SEL_SETEN),
    .en_clr(wr_hit && sel == SEL_CLREN),
    .status(stat_w), .enable(en_w)
  );

  assign pend_w = stat_w & en_w;

  irq_hub_prio #(.NUM_IN(NUM_IN)) prio_i (
    .req(pend_w), .found(found_w), .idx(idx_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      me_q  <= 1'b0;
      hie_q <= 1'b0;
    end else if (wr_hit && sel == SEL_MASTER) begin
      me_q  <= bus_wdata[0];
      hie_q <= hie_q | bus_wdata[1];
    end
  end

  always_comb begin
    rd_next = '0;
    if (in_map) begin
      unique case (sel)
        SEL_STAT:   rd_next = 32'(stat_w);
        SEL_PEND:   rd_next = 32'(pend_w);
        SEL_EN:     rd_next = 32'(en_w);
        SEL_VEC:    rd_next = found_w ? 32'(idx_w) : VEC_NONE;
        SEL_MASTER: rd_next = {30'b0, hie_q, me_q};
        default:    rd_next = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq_out   <= 1'b0;
    end else begin
      bus_rdata <= rd_next;
      irq_out   <= me_q & hie_q & (|pend_w);
    end
  end
endmodule

// File: rtl/irq_hub_chk.sv
module irq_hub_chk #(
  parameter int unsigned NUM_IN = 32,
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic              irq_out,
  input logic [NUM_IN-1:0] pend,
  input logic [NUM_IN-1:0] en_q,
  input logic              me,
  input logic              hie
);
  localparam logic [ADDR_W-1:0] A_EN  = ADDR_W'(32'h08);
  localparam logic [ADDR_W-1:0] A_SET = ADDR_W'(32'h10);
  localparam logic [ADDR_W-1:0] A_CLR = ADDR_W'(32'h14);
  localparam logic [ADDR_W-1:0] A_VEC = ADDR_W'(32'h18);

  p_vec_empty_r8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(bus_addr) == A_VEC && $past(pend) == '0)
      |-> bus_rdata == 32'hFFFF_FFFF);

  p_hie_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    $past(hie) |-> hie);

  p_irq_gate_r9: assert property (@(posedge clk) disable iff (rst)
    irq_out |-> $past(me && hie && (pend != '0)));

  p_en_zero_r4: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && bus_we && bus_addr == A_EN && bus_wdata == 32'h0) |-> en_q == '0);

  p_set_mask_r5: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && bus_we && bus_addr == A_SET)
      |-> (en_q & $past(bus_wdata[NUM_IN-1:0])) == $past(bus_wdata[NUM_IN-1:0]));

  p_clr_mask_r5: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && bus_we && bus_addr == A_CLR)
      |-> (en_q & $past(bus_wdata[NUM_IN-1:0])) == '0);
endmodule

bind irq_hub irq_hub_chk #(.NUM_IN(NUM_IN), .ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out),
  .pend(pend_w), .en_q(en_w), .me(me_q), .hie(hie_q)
);

// File: tb/irq_hub_tb_top.sv
module irq_hub_tb_top;
  localparam int unsigned NIN = 32;
  localparam int unsigned AW  = 8;
  localparam logic [31:0] EMASK = 32'h0000_00FF;  // sources 0..7 edge, rest level

  localparam logic [7:0] A_STAT = 8'h00, A_PEND = 8'h04, A_EN = 8'h08, A_ACK = 8'h0C,
                         A_SET = 8'h10, A_CLR = 8'h14, A_VEC = 8'h18, A_MST = 8'h1C;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_we = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NIN-1:0] src = '0;
  logic          irq_out;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  irq_hub #(.NUM_IN(NIN), .ADDR_W(AW), .EDGE_MASK(EMASK)) dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_in(src), .irq_out(irq_out)
  );

  // {op(1=write,0=read-check), req, addr, data, expected}
  localparam int NV = 18;
  localparam logic [79:0] TBL [NV] = '{
    {4'd0, 4'd1,  A_EN,   32'h0,          32'h0},          // R1 enable after reset
    {4'd1, 4'd4,  A_EN,   32'hF0F0_1234,  32'h0},
    {4'd0, 4'd4,  A_EN,   32'h0,          32'hF0F0_1234},  // R4
    {4'd1, 4'd5,  A_SET,  32'h0000_000F,  32'h0},
    {4'd0, 4'd5,  A_EN,   32'h0,          32'hF0F0_123F},  // R5 set-enable
    {4'd1, 4'd5,  A_CLR,  32'hF000_0030,  32'h0},
    {4'd0, 4'd5,  A_EN,   32'h0,          32'h00F0_120F},  // R5 clear-enable
    {4'd0, 4'd10, A_SET,  32'h0,          32'h0},          // R10 write-only reads zero
    {4'd0, 4'd10, 8'h20,  32'h0,          32'h0},          // R10 unmapped
    {4'd1, 4'd9,  A_MST,  32'h3,          32'h0},
    {4'd0, 4'd9,  A_MST,  32'h0,          32'h3},          // R9 read back 3
    {4'd1, 4'd9,  A_MST,  32'h0,          32'h0},
    {4'd0, 4'd9,  A_MST,  32'h0,          32'h2},          // R9 hardware enable sticky
    {4'd1, 4'd4,  A_EN,   32'h0,          32'h0},
    {4'd0, 4'd4,  A_EN,   32'h0,          32'h0},          // R4 zero masks all
    {4'd0, 4'd8,  A_VEC,  32'h0,          32'hFFFF_FFFF},  // R8 none pending
    {4'd1, 4'd10, A_STAT, 32'h0000_FFFF,  32'h0},
    {4'd0, 4'd10, A_STAT, 32'h0,          32'h0}           // R10 status write ignored
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input string tag, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0;
    @(posedge clk);
    #1 chk(tag, bus_rdata, exp);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    idle(3);
    chk("R1 irq_out in reset", {31'b0, irq_out}, 32'h0);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1 chk("R1 rdata after reset", bus_rdata, 32'h0);
    rd("R1 status", A_STAT, 32'h0);
    rd("R1 master", A_MST, 32'h0);

    for (int v = 0; v < NV; v++) begin
      if (TBL[v][79:76] == 4'd1) wr(TBL[v][71:64], TBL[v][63:32]);
      else rd($sformatf("R%0d table %0d", TBL[v][75:72], v), TBL[v][71:64], TBL[v][31:0]);
    end

    // R2 / R7: edge pulse on disabled source 3 still latches
    @(negedge clk); src[3] = 1'b1; @(negedge clk); src[3] = 1'b0;
    idle(3);
    rd("R2 edge latched after fall", A_STAT, 32'h0000_0008);
    rd("R7 pending masked while disabled", A_PEND, 32'h0);
    chk("R9 irq low while disabled", {31'b0, irq_out}, 32'h0);

    // R7 / R8 / R9: enable and turn on master
    wr(A_SET, 32'h0000_0008);
    wr(A_MST, 32'h1);
    rd("R7 pending", A_PEND, 32'h0000_0008);
    rd("R8 vector index", A_VEC, 32'h3);
    idle(2);
    chk("R9 irq high", {31'b0, irq_out}, 32'h1);

    // R3: level source 10 held high, acked while high
    @(negedge clk); src[10] = 1'b1;
    idle(3);
    wr(A_SET, 32'h0000_0400);
    rd("R8 lowest index wins", A_VEC, 32'h3);
    wr(A_ACK, 32'h0000_0008);
    rd("R8 next index", A_VEC, 32'd10);
    wr(A_ACK, 32'h0000_0400);
    idle(2);
    rd("R3 ack while high no lasting effect", A_STAT, 32'h0000_0400);
    @(negedge clk); src[10] = 1'b0;
    idle(3);
    wr(A_ACK, 32'h0000_0400);
    idle(1);
    rd("R3 cleared after fall and ack", A_STAT, 32'h0);

    // R6: selective and full acknowledge
    @(negedge clk); src[0] = 1'b1; src[5] = 1'b1;
    @(negedge clk); src[0] = 1'b0; src[5] = 1'b0;
    idle(3);
    rd("R6 two latched", A_STAT, 32'h0000_0021);
    wr(A_ACK, 32'h0000_0001);
    rd("R6 only matching bit cleared", A_STAT, 32'h0000_0020);
    wr(A_ACK, 32'hFFFF_FFFF);
    rd("R6 all ones clears all", A_STAT, 32'h0);
    idle(2);
    chk("R9 irq low when nothing pending", {31'b0, irq_out}, 32'h0);

    // R9: master enable off blocks request though pending
    wr(A_SET, 32'h0000_0002);
    @(negedge clk); src[1] = 1'b1; @(negedge clk); src[1] = 1'b0;
    idle(3);
    idle(1);
    chk("R9 irq with master on", {31'b0, irq_out}, 32'h1);
    wr(A_MST, 32'h0);
    rd("R9 master reads 2", A_MST, 32'h2);
    idle(2);
    chk("R9 irq blocked by master off", {31'b0, irq_out}, 32'h0);
    rd("R8 vector with master off", A_VEC, 32'h1);

    // R2: edge source held high does not re-latch after ack
    @(negedge clk); src[2] = 1'b1;
    idle(3);
    rd("R2 rise latched", A_STAT, 32'h0000_0006);
    wr(A_ACK, 32'hFFFF_FFFF);
    idle(3);
    rd("R2 held high no re-latch", A_STAT, 32'h0);
    @(negedge clk); src[2] = 1'b0;

    // R1: reset clears state again
    @(negedge clk); rst = 1'b1;
    idle(2);
    @(negedge clk); rst = 1'b0;
    rd("R1 enable after second reset", A_EN, 32'h0);
    rd("R1 master after second reset", A_MST, 32'h0);

    finish_run();
  end
endmodule